// File: doc/BRIEF.md
# Gated Horizontal Sync Pulse Counter

This block measures the horizontal line rate of an incoming video signal. It counts rising edges of an already synchronised horizontal sync input over a gate interval. The gate is one of two kinds. It can be the span between two consecutive vertical sync pulses, or it can be a fixed window of 2048 or 4096 ticks of an external 8 µs timebase, which is 16.384 ms or 32.768 ms. At the end of every gate the running count is copied into a read register, a one-cycle strobe is raised, and the counter starts again for the next gate.

Software controls the block through one write port. A two-bit gate-select field picks the gate source, and the encoding zero is rejected. A separate write-one-to-clear bit clears a sticky overflow flag. Clearing the flag does not disturb the running count.

When the gate source changes, the window timer and the pulse counter both restart. This keeps a gate of mixed length from ever being latched.

Top module: `hsync_gate_counter`

## Requirements
- R1: After reset, `count_o` is 0, `ovf_o` is 0, `count_vld_o` is 0 and `gate_sel_o` is 2'b01, which selects the vertical-sync gate.
- R2: With `gate_sel_o` = 2'b01, every rising edge of `vsync_i` ends a gate. In the next cycle `count_vld_o` is high for exactly one cycle, and `count_o` holds the number of `hsync_i` rising edges counted since the previous gate end.
- R3: An `hsync_i` rising edge in the same cycle as a gate end is not counted in the gate that is closing. It counts toward the next gate.
- R4: Gate-select 2'b10 ends a gate every 2048 `tick_i` pulses, and 2'b11 ends a gate every 4096 `tick_i` pulses. The window timer advances only on cycles where `tick_i` is high.
- R5: A write whose `wr_data_i[1:0]` is 2'b00 leaves the gate selection unchanged and does not restart counting.
- R6: A write that selects a different legal gate source clears the running count and the window timer, and latches nothing. In the fixed-window modes, the first gate then ends exactly one window length after the write.
- R7: An `hsync_i` rising edge that arrives while the running count is all ones sets `ovf_o`, and the running count wraps to zero.
- R8: `ovf_o` stays set across gate ends until a write with `wr_data_i[2]` = 1 clears it. That clear leaves the running count unchanged. If a set and a clear happen in the same cycle, the set wins.
- R9: A write that selects the gate source already in use does not restart the count or the window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| hsync_i | input | 1 | Synchronised horizontal sync, rising edges counted |
| vsync_i | input | 1 | Synchronised vertical sync, rising edge ends a gate in mode 2'b01 |
| tick_i | input | 1 | One-cycle 8 µs timebase pulse |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 3 | [1:0] gate select (01 vsync, 10 short, 11 long, 00 rejected), [2] overflow clear |
| gate_sel_o | output | 2 | Current gate selection |
| count_o | output | CNT_W | Latched pulse count of the last completed gate |
| count_vld_o | output | 1 | One-cycle strobe when `count_o` updates |
| ovf_o | output | 1 | Sticky counter overflow flag |

## Verification
The assertions check properties that hold on every cycle. The gate selection never holds the rejected code and does not move on a 00 write. Every gate end copies the running count into the read register together with a strobe. A restart zeroes the count without latching. The overflow flag rises only on an edge at the all-ones count, holds until cleared, and a clear does not touch the running count. Other behaviour can only be shown by the bench scenarios. These cover the exact window lengths in ticks, the first gate after a mode change, which gate an edge that coincides with a gate end belongs to, and the count after wrap-around when a clear falls between overflow and latch.

// File: rtl/hgc_pkg.sv
package hgc_pkg;
  typedef enum logic [1:0] {
    SEL_BAD   = 2'b00,
    SEL_VSYNC = 2'b01,
    SEL_SHORT = 2'b10,
    SEL_LONG  = 2'b11
  } gate_sel_e;

  localparam int unsigned WR_W    = 3;
  localparam int unsigned CLR_BIT = 2;
endpackage

// File: rtl/hgc_rise_det.sv
module hgc_rise_det #(
  parameter int unsigned W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= lvl_i;
  end

  for (genvar g = 0; g < W; g++) begin : g_bit
    assign rise_o[g] = lvl_i[g] & ~prev_q[g];
  end
endmodule

// File: rtl/hgc_ctrl.sv
module hgc_ctrl
  import hgc_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_en_i,
  input  logic [WR_W-1:0] wr_data_i,
  output gate_sel_e       sel_o,
  output logic            restart_o,
  output logic            clr_o
);
  gate_sel_e sel_q;
  gate_sel_e wr_sel;
  logic      sel_ok;

  assign wr_sel    = gate_sel_e'(wr_data_i[1:0]);
  assign sel_ok    = wr_en_i && (wr_sel != SEL_BAD);
  assign restart_o = sel_ok && (wr_sel != sel_q);
  assign clr_o     = wr_en_i && wr_data_i[CLR_BIT];
  assign sel_o     = sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sel_q <= SEL_VSYNC;
    else if (sel_ok) sel_q <= wr_sel;
  end
endmodule

// File: rtl/hgc_gate_gen.sv
module hgc_gate_gen
  import hgc_pkg::*;
#(
  parameter int unsigned SHORT_TICKS = 2048,
  parameter int unsigned LONG_TICKS  = 4096
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  gate_sel_e sel_i,
  input  logic      restart_i,
  input  logic      tick_i,
  input  logic      vs_rise_i,
  output logic      gate_end_o
);
  localparam int unsigned TW = $clog2(LONG_TICKS) + 1;
  localparam logic [TW-1:0] SHORT_LIM = TW'(SHORT_TICKS - 1);
  localparam logic [TW-1:0] LONG_LIM  = TW'(LONG_TICKS - 1);

  logic [TW-1:0] win_q;
  logic [TW-1:0] lim;
  logic          fixed;
  logic          win_end;

  assign fixed      = (sel_i == SEL_SHORT) || (sel_i == SEL_LONG);
  assign lim        = (sel_i == SEL_LONG) ? LONG_LIM : SHORT_LIM;
  assign win_end    = fixed && tick_i && (win_q == lim);
  assign gate_end_o = fixed ? win_end : vs_rise_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     win_q <= '0;
    else if (restart_i || win_end)   win_q <= '0;
    else if (fixed && tick_i)        win_q <= win_q + 1'b1;
  end
endmodule

// File: rtl/hgc_pulse_ctr.sv
module hgc_pulse_ctr #(
  parameter int unsigned CNT_W = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hs_rise_i,
  input  logic             gate_end_i,
  input  logic             restart_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] count_o,
  output logic             vld_o,
  output logic             ovf_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lat_q;
  logic             vld_q;
  logic             ovf_q;
  logic             ovf_set;

  // wrap edge only counted when not absorbed by a restart or gate end
  assign ovf_set = hs_rise_i && (&cnt_q) && !restart_i && !gate_end_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      lat_q <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= 1'b0;
      if (restart_i) begin
        cnt_q <= '0;
      end else if (gate_end_i) begin
        lat_q <= cnt_q;
        vld_q <= 1'b1;
        cnt_q <= hs_rise_i ? CNT_W'(1) : '0;
      end else if (hs_rise_i) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ovf_q <= 1'b0;
    else if (ovf_set) ovf_q <= 1'b1;
    else if (clr_i)   ovf_q <= 1'b0;
  end

  assign cnt_o   = cnt_q;
  assign count_o = lat_q;
  assign vld_o   = vld_q;
  assign ovf_o   = ovf_q;
endmodule

// File: rtl/hsync_gate_counter.sv
module hsync_gate_counter
  import hgc_pkg::*;
#(
  parameter int unsigned CNT_W       = 14,
  parameter int unsigned SHORT_TICKS = 2048,
  parameter int unsigned LONG_TICKS  = 4096
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hsync_i,
  input  logic             vsync_i,
  input  logic             tick_i,
  input  logic             wr_en_i,
  input  logic [2:0]       wr_data_i,
  output logic [1:0]       gate_sel_o,
  output logic [CNT_W-1:0] count_o,
  output logic             count_vld_o,
  output logic             ovf_o
);
  logic [1:0]       rise;
  logic             hs_rise;
  logic             vs_rise;
  gate_sel_e        sel;
  logic             restart;
  logic             clr;
  logic             gate_end;
  logic [CNT_W-1:0] cnt_run;

  hgc_rise_det #(.W(2)) u_rise (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  ({vsync_i, hsync_i}),
    .rise_o (rise)
  );
  assign hs_rise = rise[0];
  assign vs_rise = rise[1];

  hgc_ctrl u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .sel_o     (sel),
    .restart_o (restart),
    .clr_o     (clr)
  );

  hgc_gate_gen #(
    .SHORT_TICKS (SHORT_TICKS),
    .LONG_TICKS  (LONG_TICKS)
  ) u_gate (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sel_i      (sel),
    .restart_i  (restart),
    .tick_i     (tick_i),
    .vs_rise_i  (vs_rise),
    .gate_end_o (gate_end)
  );

  hgc_pulse_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hs_rise_i  (hs_rise),
    .gate_end_i (gate_end),
    .restart_i  (restart),
    .clr_i      (clr),
    .cnt_o      (cnt_run),
    .count_o    (count_o),
    .vld_o      (count_vld_o),
    .ovf_o      (ovf_o)
  );

  assign gate_sel_o = sel;
endmodule

// File: rtl/hsync_gate_counter_chk.sv
module hsync_gate_counter_chk #(
  parameter int unsigned CNT_W = 14
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic [2:0]       wr_data_i,
  input logic [1:0]       gate_sel_o,
  input logic             hs_rise,
  input logic             gate_end,
  input logic             restart,
  input logic [CNT_W-1:0] cnt_run,
  input logic [CNT_W-1:0] count_o,
  input logic             count_vld_o,
  input logic             ovf_o
);
  // R1
  sel_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_sel_o != 2'b00);

  // R5
  bad_sel_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_data_i[1:0] == 2'b00) |=> $stable(gate_sel_o));

  // R2
  latch_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gate_end && !restart) |=> (count_vld_o && count_o == $past(cnt_run)));

  // R6
  restart_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart |=> (cnt_run == '0 && !count_vld_o));

  // R7
  ovf_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_o) |-> $past(hs_rise && (&cnt_run)));

  // R8
  ovf_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !(wr_en_i && wr_data_i[2])) |=> ovf_o);

  // R8
  clr_keeps_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_data_i[2] && !restart && !gate_end && !hs_rise) |=> $stable(cnt_run));
endmodule

bind hsync_gate_counter hsync_gate_counter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_en_i     (wr_en_i),
  .wr_data_i   (wr_data_i),
  .gate_sel_o  (gate_sel_o),
  .hs_rise     (hs_rise),
  .gate_end    (gate_end),
  .restart     (restart),
  .cnt_run     (cnt_run),
  .count_o     (count_o),
  .count_vld_o (count_vld_o),
  .ovf_o       (ovf_o)
);

// File: tb/hsync_gate_counter_test.sv
module hsync_gate_counter_test;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 14;
  localparam int SHORT_L    = 2048;
  localparam int LONG_L     = 4096;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             hsync_i = 1'b0;
  logic             vsync_i = 1'b0;
  logic             tick_i = 1'b1;
  logic             wr_en_i = 1'b0;
  logic [2:0]       wr_data_i = '0;
  logic [1:0]       gate_sel_o;
  logic [CNT_W-1:0] count_o;
  logic             count_vld_o;
  logic             ovf_o;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  int exp_q[$];
  int vld_cyc_q[$];

  hsync_gate_counter uut (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .hsync_i     (hsync_i),
    .vsync_i     (vsync_i),
    .tick_i      (tick_i),
    .wr_en_i     (wr_en_i),
    .wr_data_i   (wr_data_i),
    .gate_sel_o  (gate_sel_o),
    .count_o     (count_o),
    .count_vld_o (count_vld_o),
    .ovf_o       (ovf_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // monitor: pop expected latch values as strobes appear
  always @(negedge clk_i) begin
    if (rst_ni && count_vld_o) begin
      vld_cyc_q.push_back(cyc);
      if (exp_q.size() == 0) begin
        check(1'b0, "R2 unexpected latch", int'(count_o), -1);
      end else begin
        int e;
        e = exp_q.pop_front();
        check(int'(count_o) == e, "R2/R3/R4 latched count", int'(count_o), e);
      end
    end
  end

  task automatic hs_pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i) hsync_i = 1'b1;
      @(negedge clk_i) hsync_i = 1'b0;
    end
  endtask

  task automatic vs_pulse();
    @(negedge clk_i) vsync_i = 1'b1;
    @(negedge clk_i) vsync_i = 1'b0;
    repeat (2) @(negedge clk_i);
  endtask

  task automatic wr(input logic [2:0] d);
    @(negedge clk_i);
    wr_en_i   = 1'b1;
    wr_data_i = d;
    @(negedge clk_i);
    wr_en_i   = 1'b0;
  endtask

  task automatic wait_strobes(input int n);
    while (vld_cyc_q.size() < n) @(negedge clk_i);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    total++;
    bad++;
    $display("FAIL watchdog act=%0d exp=%0d", cyc, 200000);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int c0;
    int d;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    check(count_o == '0, "R1 count", int'(count_o), 0);
    check(ovf_o == 1'b0, "R1 ovf", int'(ovf_o), 0);
    check(count_vld_o == 1'b0, "R1 strobe", int'(count_vld_o), 0);
    check(gate_sel_o == 2'b01, "R1 gate sel", int'(gate_sel_o), 1);

    // R2 vsync gates
    exp_q.push_back(0);  vs_pulse();
    exp_q.push_back(5);  hs_pulses(5);  vs_pulse();
    exp_q.push_back(37); hs_pulses(37); vs_pulse();
    exp_q.push_back(0);  vs_pulse();

    // R3 edge coincident with gate end goes to next gate
    exp_q.push_back(0);
    @(negedge clk_i); hsync_i = 1'b1; vsync_i = 1'b1;
    @(negedge clk_i); hsync_i = 1'b0; vsync_i = 1'b0;
    exp_q.push_back(3); hs_pulses(2); vs_pulse();

    // R5 rejected code keeps selection and count
    hs_pulses(2);
    wr(3'b000);
    check(gate_sel_o == 2'b01, "R5 sel after 00 write", int'(gate_sel_o), 1);
    hs_pulses(2);
    exp_q.push_back(4); vs_pulse();
    check(exp_q.size() == 0, "R5 pending latches", exp_q.size(), 0);

    // R4 R6 short window
    vld_cyc_q.delete();
    hs_pulses(3);               // discarded by restart
    exp_q.push_back(10); exp_q.push_back(0);
    wr(3'b010);
    c0 = cyc;
    check(gate_sel_o == 2'b10, "R6 sel short", int'(gate_sel_o), 2);
    hs_pulses(10);
    wait_strobes(2);
    d = vld_cyc_q[0] - c0;
    check(d == SHORT_L, "R6 first short gate", d, SHORT_L);
    d = vld_cyc_q[1] - vld_cyc_q[0];
    check(d == SHORT_L, "R4 short period", d, SHORT_L);

    // R4 R6 long window, switched mid short window
    vld_cyc_q.delete();
    hs_pulses(4);               // discarded by restart
    exp_q.push_back(3); exp_q.push_back(0);
    wr(3'b011);
    c0 = cyc;
    hs_pulses(3);
    wait_strobes(2);
    d = vld_cyc_q[0] - c0;
    check(d == LONG_L, "R6 first long gate", d, LONG_L);
    d = vld_cyc_q[1] - vld_cyc_q[0];
    check(d == LONG_L, "R4 long period", d, LONG_L);

    // back to vsync gate
    hs_pulses(6);               // discarded by restart
    wr(3'b001);
    exp_q.push_back(2); hs_pulses(2); vs_pulse();

    // R7 overflow and wrap
    hs_pulses((1 << CNT_W) + 4);
    check(ovf_o == 1'b1, "R7 ovf set", int'(ovf_o), 1);
    exp_q.push_back(4); vs_pulse();
    // R8 sticky across gate end
    check(ovf_o == 1'b1, "R8 ovf sticky", int'(ovf_o), 1);
    hs_pulses(4);
    // R8 R9 clear with same selection: no restart, count kept
    wr(3'b101);
    check(ovf_o == 1'b0, "R8 ovf cleared", int'(ovf_o), 0);
    hs_pulses(3);
    exp_q.push_back(7); vs_pulse();
    check(exp_q.size() == 0, "R9 all latches seen", exp_q.size(), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule